// File: doc/BRIEF.md
# Shared Bus Register Transfer Unit

This block is the datapath of a small accumulator machine built around one shared 16-bit bus. The six working registers sit on the bus with a 4096-word memory: a 12-bit address register and a 12-bit program counter, and 16-bit data, accumulator, instruction and temporary registers. A 3-bit source code picks the one source that drives the bus. Every register has its own clear, load and increment strobes. The memory is always addressed by the address register and is written from the bus. The accumulator never loads from the bus. It takes the result of an external ALU, so a bus transfer and an accumulator update can happen in the same cycle.

Characters enter and leave through two 8-bit stream ports with valid/ready handshakes. The input holding register accepts a character only while it is empty, and a control strobe frees it. The output register loads from the low byte of the bus. It then presents the character until the consumer accepts it. A load that arrives while an earlier character is still pending and not being accepted is dropped. The ALU function logic and the control sequencing that drives the strobes belong to other blocks.

Top module: `bxu_top`

## Requirements
- R1: The bus carries the source picked by `sel`: 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register, and 7 the memory word at the address held in the address register.
- R2: When the address register or the program counter drives the bus, bus bits 15..12 are 0.
- R3: A register whose load strobe is high captures the bus on the next clock edge. The two 12-bit registers take bus bits 11..0.
- R4: On any register, clear wins over load and load wins over increment. Increment adds one modulo 2 to the register width. Strobe bit index selects the register: 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 temporary.
- R5: The accumulator loads `alu_res` (not the bus) on its load strobe. Without any of its three strobes it keeps its value, whatever the bus carries.
- R6: With `mem_wr` high, the bus value is written to the memory word at the address register's value on the clock edge. A later `sel`=7 returns that word.
- R7: A bus transfer into a register and an accumulator load from `alu_res` in the same cycle both take effect. The data register and the accumulator can therefore swap in one cycle.
- R8: `in_ready` is high exactly while the input holding register is empty. A character with `in_valid` and `in_ready` both high is stored and shown on `inpr`. `inp_take` empties the register. `in_valid` while full changes nothing.
- R9: `outr_ld` loads bus bits 7..0 into the output register and raises `out_valid` when none is pending or the pending one is accepted that cycle. `out_valid` and `out_data` hold until `out_ready`. A load while blocked is dropped.
- R10: Reset (active low, asynchronous) clears all six registers and both character registers, leaves `in_ready` high and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Bus source code |
| ld | input | 6 | Load strobes, one per register |
| inr | input | 6 | Increment strobes, one per register |
| clr | input | 6 | Clear strobes, one per register |
| mem_wr | input | 1 | Write the bus into memory at the address register |
| alu_res | input | 16 | ALU result for the accumulator |
| inp_take | input | 1 | Free the input holding register |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Input holding register empty |
| in_data | input | 8 | Input character |
| outr_ld | input | 1 | Load output register from bus bits 7..0 |
| out_valid | output | 1 | Output character pending |
| out_ready | input | 1 | Consumer accepts the output character |
| out_data | output | 8 | Output character |
| bus | output | 16 | Shared bus value |
| ar | output | 12 | Address register |
| pc | output | 12 | Program counter |
| dr | output | 16 | Data register |
| ac | output | 16 | Accumulator |
| ir | output | 16 | Instruction register |
| tr | output | 16 | Temporary register |
| inpr | output | 8 | Input holding register |

## Verification
Some rules are checked by assertions on every cycle: the zero bus on code 0, the zero upper bits when a narrow register drives the bus, clear and load on the data register, the accumulator keeping its value without strobes, and the stability of both stream handshakes. Only the bench's scenarios show the rest: the full source map including memory read-back after a write, the three-way strobe priority and the increment wrap, the one-cycle swap through the ALU path, and the dropping of an output load under back-pressure.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } src_e;

  localparam int NREG   = 6;
  localparam int IDX_AR = 0;
  localparam int IDX_PC = 1;
  localparam int IDX_DR = 2;
  localparam int IDX_AC = 3;
  localparam int IDX_IR = 4;
  localparam int IDX_TR = 5;
endpackage

// File: rtl/bxu_reg.sv
module bxu_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // clear over load over increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= din;
    else if (inr) q <= q + W'(1);
  end
endmodule

// File: rtl/bxu_mem.sv
module bxu_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/bxu_chario.sv
module bxu_chario #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              inp_take,
  output logic [CHAR_W-1:0] inpr,
  input  logic              outr_ld,
  input  logic [CHAR_W-1:0] out_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data
);
  logic in_full;
  logic out_free;

  assign in_ready = !in_full;
  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full <= 1'b0;
      inpr    <= '0;
    end else if (!in_full && in_valid) begin
      in_full <= 1'b1;
      inpr    <= in_data;
    end else if (in_full && inp_take) begin
      in_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (outr_ld && out_free) begin
      out_valid <= 1'b1;
      out_data  <= out_src;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bxu_top.sv
module bxu_top
  import bxu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic [NREG-1:0]   ld,
  input  logic [NREG-1:0]   inr,
  input  logic [NREG-1:0]   clr,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              inp_take,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              outr_ld,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] ar,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] tr,
  output logic [CHAR_W-1:0] inpr
);
  logic [NREG-1:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0]           mem_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int W = (i == IDX_AR || i == IDX_PC) ? ADDR_W : DATA_W;
    logic [W-1:0] din;
    logic [W-1:0] q;
    if (i == IDX_AC) begin : g_alu
      assign din = alu_res[W-1:0];
    end else begin : g_bus
      assign din = bus[W-1:0];
    end
    bxu_reg #(.W(W)) u_reg (
      .clk(clk), .rst_n(rst_n), .clr(clr[i]), .ld(ld[i]), .inr(inr[i]),
      .din(din), .q(q)
    );
    assign reg_q[i] = DATA_W'(q);
  end

  bxu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_wr), .addr(ar), .wdata(bus), .rdata(mem_q)
  );

  always_comb begin
    unique case (src_e'(sel))
      SRC_AR:  bus = reg_q[IDX_AR];
      SRC_PC:  bus = reg_q[IDX_PC];
      SRC_DR:  bus = reg_q[IDX_DR];
      SRC_AC:  bus = reg_q[IDX_AC];
      SRC_IR:  bus = reg_q[IDX_IR];
      SRC_TR:  bus = reg_q[IDX_TR];
      SRC_MEM: bus = mem_q;
      default: bus = '0;
    endcase
  end

  assign ar = reg_q[IDX_AR][ADDR_W-1:0];
  assign pc = reg_q[IDX_PC][ADDR_W-1:0];
  assign dr = reg_q[IDX_DR];
  assign ac = reg_q[IDX_AC];
  assign ir = reg_q[IDX_IR];
  assign tr = reg_q[IDX_TR];

  bxu_chario #(.CHAR_W(CHAR_W)) u_chario (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .inp_take(inp_take), .inpr(inpr),
    .outr_ld(outr_ld), .out_src(bus[CHAR_W-1:0]),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/bxu_checker.sv
module bxu_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        sel,
  input logic [5:0]        ld,
  input logic [5:0]        inr,
  input logic [5:0]        clr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] out_data,
  input logic [DATA_W-1:0] bus,
  input logic [DATA_W-1:0] dr,
  input logic [DATA_W-1:0] ac
);
  a_r1_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd0 |-> bus == '0);

  a_r2_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd1 || sel == 3'd2) |-> bus[DATA_W-1:ADDR_W] == '0);

  a_r3_dr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld[2] && !clr[2]) |=> dr == $past(bus));

  a_r4_dr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr[2] |=> dr == '0);

  a_r5_ac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr[3] && !ld[3] && !inr[3]) |=> $stable(ac));

  a_r8_in_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bxu_top bxu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .ld(ld), .inr(inr), .clr(clr),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .bus(bus), .dr(dr), .ac(ac)
);

// File: tb/bxu_top_test.sv
module bxu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0;
  logic [5:0]  ld = '0, inr = '0, clr = '0;
  logic        mem_wr = 1'b0;
  logic [15:0] alu_res = '0;
  logic        inp_take = 1'b0, in_valid = 1'b0, outr_ld = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data, inpr;
  logic [15:0] bus, dr, ac, ir, tr;
  logic [11:0] ar, pc;

  int checks = 0;
  int errors = 0;

  logic [15:0] m [6];
  logic [15:0] mmem [4096];
  bit          wrote [4096];
  logic        m_full, m_ov;
  logic [7:0]  m_inpr, m_out;

  bxu_top uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ld(ld), .inr(inr), .clr(clr),
    .mem_wr(mem_wr), .alu_res(alu_res), .inp_take(inp_take),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .outr_ld(outr_ld), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .bus(bus), .ar(ar), .pc(pc), .dr(dr), .ac(ac),
    .ir(ir), .tr(tr), .inpr(inpr)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] wmask(int i);
    return (i < 2) ? 16'h0FFF : 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_bus();
    case (sel)
      3'd0:    return 16'h0000;
      3'd7:    return mmem[m[0][11:0]];
      default: return m[sel - 1];
    endcase
  endfunction

  task automatic compare_all();
    chk("R3 R4 ar", {4'h0, ar}, m[0]);
    chk("R3 R4 pc", {4'h0, pc}, m[1]);
    chk("R3 R4 dr", dr, m[2]);
    chk("R5 ac", ac, m[3]);
    chk("R3 R4 ir", ir, m[4]);
    chk("R3 R4 tr", tr, m[5]);
    chk("R8 in_ready", {15'h0, in_ready}, {15'h0, !m_full});
    chk("R8 inpr", {8'h0, inpr}, {8'h0, m_inpr});
    chk("R9 out_valid", {15'h0, out_valid}, {15'h0, m_ov});
    chk("R9 out_data", {8'h0, out_data}, {8'h0, m_out});
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic step();
    logic [15:0] b;
    logic [15:0] nx [6];
    #2;
    b = exp_bus();
    chk("R1 bus", bus, b);
    for (int i = 0; i < 6; i++) begin
      if (clr[i])     nx[i] = 16'h0;
      else if (ld[i]) nx[i] = ((i == 3) ? alu_res : b) & wmask(i);
      else if (inr[i]) nx[i] = (m[i] + 16'h1) & wmask(i);
      else            nx[i] = m[i];
    end
    if (mem_wr) begin
      mmem[m[0][11:0]] = b;
      wrote[m[0][11:0]] = 1'b1;
    end
    if (!m_full && in_valid) begin
      m_full = 1'b1; m_inpr = in_data;
    end else if (m_full && inp_take) m_full = 1'b0;
    if (outr_ld && (!m_ov || out_ready)) begin
      m_ov = 1'b1; m_out = b[7:0];
    end else if (m_ov && out_ready) m_ov = 1'b0;
    for (int i = 0; i < 6; i++) m[i] = nx[i];
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    sel = 3'd0; ld = '0; inr = '0; clr = '0; mem_wr = 1'b0;
    inp_take = 1'b0; in_valid = 1'b0; outr_ld = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 6; i++) m[i] = '0;
    m_full = 0; m_ov = 0; m_inpr = '0; m_out = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ac", ac, 16'h0);
    chk("R10 ar", {4'h0, ar}, 16'h0);
    chk("R10 in_ready", {15'h0, in_ready}, 16'h1);
    chk("R10 out_valid", {15'h0, out_valid}, 16'h0);
    compare_all();

    // R2: AR full of ones, upper bus bits zero
    idle(); alu_res = 16'hFFFF; ld[3] = 1'b1; step();
    idle(); sel = 3'd4; ld[0] = 1'b1; ld[1] = 1'b1; step();
    idle(); sel = 3'd1; #2; chk("R2 ar on bus", bus, 16'h0FFF);
    step();
    idle(); sel = 3'd2; #2; chk("R2 pc on bus", bus, 16'h0FFF);
    step();

    // R4 priority on data register
    idle(); sel = 3'd4; ld[2] = 1'b1; clr[2] = 1'b1; inr[2] = 1'b1; step();
    chk("R4 clr wins", dr, 16'h0);
    idle(); sel = 3'd4; ld[2] = 1'b1; inr[2] = 1'b1; step();
    chk("R4 ld over inr", dr, 16'hFFFF);
    idle(); inr[2] = 1'b1; inr[0] = 1'b1; step();
    chk("R4 wrap dr", dr, 16'h0);
    chk("R4 wrap ar", {4'h0, ar}, 16'h0);

    // R7 swap DR and AC in one cycle
    idle(); alu_res = 16'hAAAA; ld[3] = 1'b1; step();
    idle(); sel = 3'd4; ld[2] = 1'b1; alu_res = 16'h5555; ld[3] = 1'b1; step();
    idle(); sel = 3'd4; ld[2] = 1'b1; alu_res = dr; ld[3] = 1'b1; step();
    chk("R7 swap dr", dr, 16'h5555);
    chk("R7 swap ac", ac, 16'hAAAA);
    // R5 bus does not reach ac
    idle(); sel = 3'd3; step();
    chk("R5 ac kept", ac, 16'hAAAA);

    // R6 memory write and read back at AR
    idle(); sel = 3'd4; ld[0] = 1'b1; step();
    idle(); sel = 3'd3; mem_wr = 1'b1; step();
    idle(); sel = 3'd7; #2; chk("R6 mem readback", bus, 16'h5555);
    step();

    // R9 back-pressure
    idle(); sel = 3'd4; outr_ld = 1'b1; step();
    idle(); sel = 3'd3; outr_ld = 1'b1; step();
    chk("R9 dropped load", {8'h0, out_data}, 16'h00AA);
    idle(); out_ready = 1'b1; step();
    chk("R9 accepted", {15'h0, out_valid}, 16'h0);

    // R8 input stream
    idle(); in_valid = 1'b1; in_data = 8'h3C; step();
    chk("R8 stored", {8'h0, inpr}, 16'h003C);
    idle(); in_valid = 1'b1; in_data = 8'hC3; step();
    chk("R8 ignored while full", {8'h0, inpr}, 16'h003C);
    idle(); inp_take = 1'b1; step();
    chk("R8 freed", {15'h0, in_ready}, 16'h1);

    // constrained random traffic
    for (int n = 0; n < 1500; n++) begin
      sel = 3'($urandom);
      if (sel == 3'd7 && !wrote[m[0][11:0]]) sel = 3'($urandom % 7);
      ld  = 6'($urandom & $urandom);
      inr = 6'($urandom & $urandom);
      clr = 6'($urandom & $urandom & $urandom);
      mem_wr = ($urandom % 4) == 0;
      alu_res = 16'($urandom);
      in_valid = $urandom % 2; in_data = 8'($urandom);
      inp_take = $urandom % 2; outr_ld = $urandom % 2; out_ready = $urandom % 2;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule